// File: doc/BRIEF.md
# Boolean Instruction-List Bit Processor

This block is a one-bit logic engine. It runs a fixed instruction-list program from an internal ROM, one instruction per clock. Each pass over the program is a scan. The program works on a 64-bit data table that holds input images, output images and internal relays. At the start of each scan the parallel input port is copied into the input part of the table. The program then evaluates its rungs with contact loads, series and parallel contacts, and edge-sensitive contacts. It can merge separately built sub-rungs through a logic-block stack. Results go to plain or inverted coils, latching set and reset coils, or a two-line keep relay. When the program reaches its end instruction, the output part of the table is copied to the output port, and a one-cycle done strobe marks the end of the scan.

A parameter chooses the ROM image. Image 0 is the working control program. Images 1 and 2 are fault programs: image 1 nests more logic blocks than the stack holds, and image 2 combines a block with an empty stack. Either fault sets a sticky error flag and stops execution until reset.

Top module: `bitproc_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, out_bits is 0, scan_done is 0 and err is 0.
- R2: With image 0, out_bits[0] = (in0 AND in1) AND (in2 OR NOT in3). This combines two logic blocks with a block-AND. out_bits[1] is the inverse of out_bits[0], written by a negated coil.
- R3: With image 0, out_bits[6] = (in2 AND NOT in3) OR (in4 OR in5). This combines two logic blocks with a block-OR.
- R4: With image 0, out_bits[2] is set by in4 and cleared by in5. It holds its value when neither input is 1. When both are 1 in the same scan, the reset coil comes later in the program, so the bit ends at 0.
- R5: With image 0, out_bits[3] is a keep relay. in6 sets it, in7 clears it, and it holds when neither is 1. When both are 1, the result is 0 (reset wins).
- R6: With image 0, out_bits[4] is 1 only in the scan where in0 is 1 and was 0 in the previous scan (rising-edge contact). out_bits[5] is 1 only in the scan where in1 is 0 and was 1 in the previous scan (falling-edge contact). The first scan after reset treats the previous values as 0.
- R7: With image 0, an internal relay is sealed in: relay = (in0 OR relay) AND NOT in7, with the relay at 0 after reset. out_bits[7] mirrors the relay.
- R8: The inputs are sampled on the first clock edge after scan_done (or after reset is released). out_bits changes only in cycles where scan_done is 1. scan_done is a one-cycle pulse. With image 0, a scan lasts 32 cycles.
- R9: With image 1, a block load while all 8 stack entries are full sets err. After that, err stays 1, scan_done never pulses and out_bits stays 0.
- R10: With image 2, a block combine with an empty stack sets err. After that, err stays 1, scan_done never pulses and out_bits stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_bits | input | NUM_IN (8) | Parallel input port, sampled at scan start |
| out_bits | output | NUM_OUT (8) | Output port, updated at scan end |
| scan_done | output | 1 | One-cycle pulse when a scan completes |
| err | output | 1 | Sticky stack fault flag |

## Verification
The assertions assume that reset is held for at least one clock before it is released. This is because the output-stability and strobe checks compare against values registered during reset. They also assume that only the fault images can drive the stack past its limits. The stimulus meets the first assumption by holding reset for several cycles. Inputs change only on the falling edge at which scan_done is seen high, so every vector is latched on a scan boundary. Random vectors are mixed with directed sequences that press set and reset, and keep set and clear, together, and that toggle the edge contacts.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

    localparam int ADDR_W = 6;

    typedef enum logic [3:0] {
        OP_LD, OP_LDN, OP_AND, OP_ANDN, OP_OR, OP_ORN, OP_LDR, OP_LDF,
        OP_ANDBLK, OP_ORBLK, OP_OUT, OP_OUTN, OP_SET, OP_RST, OP_KEEP, OP_END
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef enum logic [1:0] {ST_LATCH, ST_EXEC, ST_HALT} state_e;

    function automatic instr_t mk(op_e o, int a);
        instr_t t;
        t.op   = o;
        t.addr = ADDR_W'(a);
        return t;
    endfunction

    function automatic logic is_load(op_e o);
        return (o == OP_LD) || (o == OP_LDN) || (o == OP_LDR) || (o == OP_LDF);
    endfunction

endpackage

// File: rtl/bitproc_rom.sv
module bitproc_rom
    import bitproc_pkg::*;
#(
    parameter int PROG      = 0,
    parameter int PC_W      = 6,
    parameter int STK_DEPTH = 8,
    parameter int NUM_IN    = 8,
    parameter int NUM_OUT   = 8
) (
    input  logic [PC_W-1:0] pc,
    output instr_t          ins
);
    localparam int RLY = NUM_IN + NUM_OUT;

    generate
        if (PROG == 0) begin : g_main
            always_comb begin
                case (int'(pc))
                    0:  ins = mk(OP_LD,   0);
                    1:  ins = mk(OP_AND,  1);
                    2:  ins = mk(OP_LD,   2);
                    3:  ins = mk(OP_ORN,  3);
                    4:  ins = mk(OP_ANDBLK, 0);
                    5:  ins = mk(OP_OUT,  NUM_IN + 0);
                    6:  ins = mk(OP_OUTN, NUM_IN + 1);
                    7:  ins = mk(OP_LD,   4);
                    8:  ins = mk(OP_SET,  NUM_IN + 2);
                    9:  ins = mk(OP_LD,   5);
                    10: ins = mk(OP_RST,  NUM_IN + 2);
                    11: ins = mk(OP_LD,   6);
                    12: ins = mk(OP_LD,   7);
                    13: ins = mk(OP_KEEP, NUM_IN + 3);
                    14: ins = mk(OP_LDR,  0);
                    15: ins = mk(OP_OUT,  NUM_IN + 4);
                    16: ins = mk(OP_LDF,  1);
                    17: ins = mk(OP_OUT,  NUM_IN + 5);
                    18: ins = mk(OP_LD,   2);
                    19: ins = mk(OP_ANDN, 3);
                    20: ins = mk(OP_LD,   4);
                    21: ins = mk(OP_OR,   5);
                    22: ins = mk(OP_ORBLK, 0);
                    23: ins = mk(OP_OUT,  NUM_IN + 6);
                    24: ins = mk(OP_LD,   0);
                    25: ins = mk(OP_OR,   RLY);
                    26: ins = mk(OP_ANDN, 7);
                    27: ins = mk(OP_OUT,  RLY);
                    28: ins = mk(OP_LD,   RLY);
                    29: ins = mk(OP_OUT,  NUM_IN + 7);
                    default: ins = mk(OP_END, 0);
                endcase
            end
        end else if (PROG == 1) begin : g_overflow
            always_comb ins = (int'(pc) < STK_DEPTH + 2) ? mk(OP_LD, 0) : mk(OP_END, 0);
        end else begin : g_underflow
            always_comb begin
                case (int'(pc))
                    0:       ins = mk(OP_LD, 0);
                    1:       ins = mk(OP_ORBLK, 0);
                    default: ins = mk(OP_END, 0);
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/bitproc_table.sv
module bitproc_table
    import bitproc_pkg::*;
#(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               latch_en,
    input  logic [NUM_IN-1:0]  in_bits,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic               wr_val,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic               rd_cur,
    output logic               rd_prv,
    input  logic               snap_en,
    output logic [NUM_OUT-1:0] out_view
);
    localparam int NBITS = 1 << ADDR_W;

    logic [NBITS-1:0] tbl;
    logic [NBITS-1:0] prv;

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl <= '0;
            prv <= '0;
        end else begin
            if (latch_en)   tbl[NUM_IN-1:0] <= in_bits;
            else if (wr_en) tbl[wr_addr]    <= wr_val;
            if (snap_en)    prv <= tbl;
        end
    end

    assign rd_cur   = tbl[rd_addr];
    assign rd_prv   = prv[rd_addr];
    assign out_view = tbl[NUM_IN +: NUM_OUT];

    // R8
    in_latch_chk: assert property (@(posedge clk) disable iff (rst)
        latch_en |=> tbl[NUM_IN-1:0] == $past(in_bits));
endmodule

// File: rtl/bitproc_stack.sv
module bitproc_stack #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic push,
    input  logic pop,
    input  logic din,
    output logic top,
    output logic full,
    output logic empty
);
    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0] mem;
    logic [SP_W-1:0]  sp;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sp <= '0;
        end else if (push) begin
            mem[IDX_W'(sp)] <= din;
            sp <= sp + 1'b1;
        end else if (pop) begin
            sp <= sp - 1'b1;
        end
    end

    assign full  = (int'(sp) == DEPTH);
    assign empty = (sp == '0);
    assign top   = empty ? 1'b0 : mem[IDX_W'(sp - 1'b1)];

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/bitproc_engine.sv
module bitproc_engine
    import bitproc_pkg::*;
#(
    parameter int NUM_IN    = 8,
    parameter int NUM_OUT   = 8,
    parameter int STK_DEPTH = 8,
    parameter int PC_W      = 6,
    parameter int PROG      = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IN-1:0]  in_bits,
    output logic [NUM_OUT-1:0] out_bits,
    output logic               scan_done,
    output logic               err
);
    state_e          state;
    logic [PC_W-1:0] pc;
    logic            acc, rung_done;
    instr_t          ins;

    logic rd_cur, rd_prv, stk_top, stk_full, stk_empty;
    logic stk_clr, stk_push, stk_pop;
    logic wr_en, wr_val, acc_n, rdone_n, fault, at_end, bitv;
    logic [NUM_OUT-1:0] out_view;

    bitproc_rom #(.PROG(PROG), .PC_W(PC_W), .STK_DEPTH(STK_DEPTH),
                  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) rom_i (.pc(pc), .ins(ins));

    bitproc_table #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) tbl_i (
        .clk(clk), .rst(rst), .latch_en(state == ST_LATCH), .in_bits(in_bits),
        .wr_en(wr_en), .wr_addr(ins.addr), .wr_val(wr_val), .rd_addr(ins.addr),
        .rd_cur(rd_cur), .rd_prv(rd_prv), .snap_en(at_end), .out_view(out_view));

    bitproc_stack #(.DEPTH(STK_DEPTH)) stk_i (
        .clk(clk), .rst(rst), .clr(stk_clr), .push(stk_push), .pop(stk_pop),
        .din(acc), .top(stk_top), .full(stk_full), .empty(stk_empty));

    always_comb begin
        case (ins.op)
            OP_LDN:  bitv = ~rd_cur;
            OP_LDR:  bitv = rd_cur & ~rd_prv;
            OP_LDF:  bitv = ~rd_cur & rd_prv;
            default: bitv = rd_cur;
        endcase
    end

    always_comb begin
        acc_n    = acc;
        rdone_n  = rung_done;
        stk_clr  = 1'b0;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        wr_en    = 1'b0;
        wr_val   = 1'b0;
        fault    = 1'b0;
        at_end   = 1'b0;
        if (state == ST_EXEC) begin
            if (is_load(ins.op)) begin
                acc_n   = bitv;
                rdone_n = 1'b0;
                if (rung_done)     stk_clr  = 1'b1;
                else if (stk_full) fault    = 1'b1;
                else               stk_push = 1'b1;
            end else begin
                case (ins.op)
                    OP_AND:  acc_n = acc & rd_cur;
                    OP_ANDN: acc_n = acc & ~rd_cur;
                    OP_OR:   acc_n = acc | rd_cur;
                    OP_ORN:  acc_n = acc | ~rd_cur;
                    OP_ANDBLK, OP_ORBLK: begin
                        if (stk_empty) fault = 1'b1;
                        else begin
                            stk_pop = 1'b1;
                            acc_n   = (ins.op == OP_ANDBLK) ? (stk_top & acc) : (stk_top | acc);
                        end
                    end
                    OP_OUT:  begin wr_en = 1'b1; wr_val = acc;  rdone_n = 1'b1; end
                    OP_OUTN: begin wr_en = 1'b1; wr_val = ~acc; rdone_n = 1'b1; end
                    OP_SET:  begin wr_en = acc;  wr_val = 1'b1; rdone_n = 1'b1; end
                    OP_RST:  begin wr_en = acc;  wr_val = 1'b0; rdone_n = 1'b1; end
                    OP_KEEP: begin
                        if (stk_empty) fault = 1'b1;
                        else begin
                            stk_pop = 1'b1;
                            wr_en   = 1'b1;
                            wr_val  = acc ? 1'b0 : (stk_top | rd_cur);
                            rdone_n = 1'b1;
                        end
                    end
                    default: at_end = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_LATCH;
            pc        <= '0;
            acc       <= 1'b0;
            rung_done <= 1'b1;
            out_bits  <= '0;
            scan_done <= 1'b0;
            err       <= 1'b0;
        end else begin
            scan_done <= 1'b0;
            case (state)
                ST_LATCH: begin
                    pc        <= '0;
                    rung_done <= 1'b1;
                    state     <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (fault) begin
                        err   <= 1'b1;
                        state <= ST_HALT;
                    end else if (at_end) begin
                        out_bits  <= out_view;
                        scan_done <= 1'b1;
                        state     <= ST_LATCH;
                    end else begin
                        acc       <= acc_n;
                        rung_done <= rdone_n;
                        pc        <= pc + 1'b1;
                    end
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !scan_done |-> $stable(out_bits));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> !scan_done);
    // R9 R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> (err && !scan_done));
    // R9 R10
    halt_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT) |-> (err && !scan_done));
endmodule

// File: tb/bitproc_engine_tb_top.sv
module bitproc_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_bits = '0;
    logic [7:0] out_bits, out_ovf, out_unf;
    logic       scan_done, done_ovf, done_unf, err, err_ovf, err_unf;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit fault_done_seen = 1'b0;

    // model state
    logic m_q2 = 0, m_q3 = 0, m_rly = 0, m_p0 = 0, m_p1 = 0;
    logic [7:0] last_out = '0;

    always #10 clk = ~clk;

    bitproc_engine #(.PROG(0)) dut_i (.clk(clk), .rst(rst), .in_bits(in_bits),
        .out_bits(out_bits), .scan_done(scan_done), .err(err));
    bitproc_engine #(.PROG(1)) dut_ovf_i (.clk(clk), .rst(rst), .in_bits(in_bits),
        .out_bits(out_ovf), .scan_done(done_ovf), .err(err_ovf));
    bitproc_engine #(.PROG(2)) dut_unf_i (.clk(clk), .rst(rst), .in_bits(in_bits),
        .out_bits(out_unf), .scan_done(done_unf), .err(err_unf));

    always @(negedge clk) begin
        cyc++;
        if (!rst && (done_ovf || done_unf)) fault_done_seen = 1'b1;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [7:0] v);
        logic [7:0] q;
        q[0] = (v[0] & v[1]) & (v[2] | ~v[3]);
        q[1] = ~q[0];
        if (v[4]) m_q2 = 1'b1;
        if (v[5]) m_q2 = 1'b0;
        q[2] = m_q2;
        if (v[7]) m_q3 = 1'b0;
        else if (v[6]) m_q3 = 1'b1;
        q[3] = m_q3;
        q[4] = v[0] & ~m_p0;
        q[5] = ~v[1] & m_p1;
        q[6] = (v[2] & ~v[3]) | v[4] | v[5];
        m_rly = (v[0] | m_rly) & ~v[7];
        q[7] = m_rly;
        m_p0 = v[0];
        m_p1 = v[1];
        return q;
    endfunction

    task automatic run_scan(input logic [7:0] v, input string req);
        int n;
        logic [7:0] exp;
        in_bits = v;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 16) chk("R8 mid-scan hold", out_bits, last_out);
        end while (!scan_done && n < 200);
        chk("R8 scan length", 8'(n), 8'd32);
        exp = model(v);
        chk(req, out_bits, exp);
        last_out = out_bits;
    endtask

    initial begin
        int k;
        k = 0;
        while (cyc < 100000) @(negedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 out", out_bits, 8'h00);
        chk("R1 flags", {6'b0, scan_done, err}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first cycle", {out_bits[5:0], scan_done, err}, 8'h00);
        in_bits = 8'h00;
        // align: run_scan starts counting from this negedge; latch is on next posedge
        begin
            int n;
            n = 1;
            while (!scan_done && n < 200) begin @(negedge clk); n++; end
            chk("R8 first scan length", 8'(n), 8'd32);
            chk("R1 R2 zeros", out_bits, model(8'h00));
            last_out = out_bits;
        end
        run_scan(8'h03, "R2 block-and true");
        run_scan(8'h0B, "R2 block-and false");
        run_scan(8'h0C, "R3 block-or");
        run_scan(8'h10, "R4 set");
        run_scan(8'h00, "R4 hold");
        run_scan(8'h20, "R4 reset");
        run_scan(8'h10, "R4 set again");
        run_scan(8'h30, "R4 both reset wins");
        run_scan(8'h40, "R5 keep set");
        run_scan(8'h00, "R5 keep hold");
        run_scan(8'hC0, "R5 keep both reset wins");
        run_scan(8'h40, "R5 keep set again");
        run_scan(8'h80, "R5 keep clear");
        run_scan(8'h01, "R6 rising edge R7 seal");
        run_scan(8'h01, "R6 no edge when held");
        run_scan(8'h02, "R6 rising edge repeat R7 held");
        run_scan(8'h00, "R6 falling edge");
        run_scan(8'h00, "R7 seal held");
        run_scan(8'h80, "R7 seal broken");
        for (int i = 0; i < 150; i++) begin
            run_scan(8'($urandom), "R2 R3 R4 R5 R6 R7 random");
        end
        // R9 overflow image, R10 underflow image
        chk("R9 err", {7'b0, err_ovf}, 8'h01);
        chk("R9 out", out_ovf, 8'h00);
        chk("R10 err", {7'b0, err_unf}, 8'h01);
        chk("R10 out", out_unf, 8'h00);
        chk("R9 R10 no done", {7'b0, fault_done_seen}, 8'h00);
        chk("R9 R10 main no err", {7'b0, err}, 8'h00);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule